// File: doc/BRIEF.md
# Nonvolatile Write Permission Gate

This block decides whether a nonvolatile write that the serial front end has just finished receiving may begin. When the front end sees the STOP condition it presents one request for one cycle. The request carries the target kind (memory array, potentiometer register or control/status register), the word address, the number of bits clocked in before STOP, and whether every byte was acknowledged. The gate weighs that request against the state of the device: the general write-enable latch, the extra enable latch that only control-register writes need, a two-bit region lock code, and the hardware write-protect pin.

On the cycle after the request exactly one of two outputs pulses. The start strobe tells the write-cycle timer to begin. The reject strobe tells the front end that the request was dropped. While a write cycle is already running, the busy input is high and requests produce no pulse at all. The latch bits and the lock code are inputs owned elsewhere, so a rejected attempt cannot disturb them.

Top module: `nvw_gate`

## Requirements
- R1: When an accepted request passes every check, `write_start` is high for exactly the one cycle after `req_valid`, and `write_reject` stays low.
- R2: When `wel` is 0, every request is rejected, whatever its target.
- R3: A request with target code 2'b10 (control/status register) is rejected unless `rwel` is 1, even when `wel` is 1.
- R4: With `lock_code` 2'b01, array targets (code 2'b00) at the upper quarter of the address space (the two address MSBs are 11) are rejected. With 2'b10, array targets with address MSB 1 are rejected. With 2'b11, all array targets and all potentiometer targets (code 2'b01) are rejected. With 2'b00 nothing is locked. The control register is never region-locked.
- R5: When `wp_pin` is 1, every request is rejected.
- R6: A request is rejected unless `ack_ok` is 1, `bit_count` is a nonzero multiple of 9, and `bit_count` is at least 9*MIN_BYTES (default MIN_BYTES=2, i.e. at least 18 bits).
- R7: Every accepted request produces exactly one pulse, either start or reject, on the following cycle. The two outputs are never high together.
- R8: A request that arrives while `busy` is 1 is ignored: neither output pulses on the following cycle.
- R9: During and right after reset both outputs are 0. Without a request, neither output pulses.
- R10: Target code 2'b11 is not a valid target, and such a request is rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | One-cycle request presented at STOP |
| req_target | input | 2 | 00 array, 01 potentiometer, 10 control register, 11 invalid |
| req_addr | input | ADDR_W | Word address of an array target |
| bit_count | input | CNT_W | Bits clocked in before STOP, acknowledge slots included |
| ack_ok | input | 1 | Every byte of the request was acknowledged |
| wel | input | 1 | General write-enable latch |
| rwel | input | 1 | Control-register write-enable latch |
| lock_code | input | 2 | Region lock code |
| wp_pin | input | 1 | Hardware write protect, active high |
| busy | input | 1 | A nonvolatile write cycle is in progress |
| write_start | output | 1 | One-cycle start strobe |
| write_reject | output | 1 | One-cycle reject strobe |

## Verification
The bench builds requests in two ways. Directed cases test each lock code against addresses just below and just above the quarter and half boundaries. Random cases vary the bit count, including counts one bit off a byte boundary, too-short frames and missing acknowledges, and they also vary the latch bits, the protect pin and the busy flag. Each expected outcome is labelled with the first rule that should refuse the request, so a failure shows which layer of permission went wrong. The busy cases and the idle cycles separate a request that was ignored from one that was rejected.

// File: rtl/nvw_pkg.sv
package nvw_pkg;

  typedef enum logic [1:0] {
    TGT_ARRAY = 2'b00,
    TGT_POT   = 2'b01,
    TGT_CTRL  = 2'b10,
    TGT_BAD   = 2'b11
  } nvw_target_e;

  typedef enum logic [1:0] {
    LOCK_NONE    = 2'b00,
    LOCK_QUARTER = 2'b01,
    LOCK_HALF    = 2'b10,
    LOCK_ALL     = 2'b11
  } nvw_lock_e;

  // True when the bit count closes on a whole number of 9-bit slots
  // (8 data bits plus an acknowledge) and covers at least min_bytes slots.
  function automatic logic frame_whole(input int unsigned bits,
                                       input int unsigned min_bytes);
    return (bits % 9 == 0) && (bits >= 9 * min_bytes) && (bits != 0);
  endfunction

  // Region test on the two top address bits of an array target.
  function automatic logic region_locked(input nvw_lock_e code,
                                         input logic [1:0] top2);
    case (code)
      LOCK_QUARTER: return top2 == 2'b11;
      LOCK_HALF:    return top2[1];
      LOCK_ALL:     return 1'b1;
      default:      return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/nvw_frame_check.sv
module nvw_frame_check
  import nvw_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int MIN_BYTES = 2
) (
  input  logic [CNT_W-1:0] bit_count,
  input  logic             ack_ok,
  output logic             frame_ok
);
  always_comb frame_ok = ack_ok && frame_whole(int'(bit_count), MIN_BYTES);
endmodule

// File: rtl/nvw_region_lock.sv
module nvw_region_lock
  import nvw_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [1:0]        req_target,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        lock_code,
  output logic              lock_hit
);
  localparam int TOP = ADDR_W - 1;
  nvw_lock_e   code;
  nvw_target_e tgt;

  always_comb begin
    code = nvw_lock_e'(lock_code);
    tgt  = nvw_target_e'(req_target);
    case (tgt)
      TGT_ARRAY: lock_hit = region_locked(code, req_addr[TOP -: 2]);
      TGT_POT:   lock_hit = (code == LOCK_ALL);
      default:   lock_hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/nvw_gate.sv
module nvw_gate
  import nvw_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int CNT_W     = 8,
  parameter int MIN_BYTES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_target,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CNT_W-1:0]  bit_count,
  input  logic              ack_ok,
  input  logic              wel,
  input  logic              rwel,
  input  logic [1:0]        lock_code,
  input  logic              wp_pin,
  input  logic              busy,
  output logic              write_start,
  output logic              write_reject
);
  // Named internal events, visible to the bound checker.
  logic frame_ok;
  logic lock_hit;
  logic enable_ok;
  logic accepted;
  logic permit;

  nvw_frame_check #(.CNT_W(CNT_W), .MIN_BYTES(MIN_BYTES)) u_frame (
    .bit_count (bit_count),
    .ack_ok    (ack_ok),
    .frame_ok  (frame_ok)
  );

  nvw_region_lock #(.ADDR_W(ADDR_W)) u_lock (
    .req_target (req_target),
    .req_addr   (req_addr),
    .lock_code  (lock_code),
    .lock_hit   (lock_hit)
  );

  always_comb begin
    enable_ok = wel && !wp_pin;
    if (req_target == TGT_CTRL) enable_ok = enable_ok && rwel;
    if (req_target == TGT_BAD)  enable_ok = 1'b0;
    accepted = req_valid && !busy;
    permit   = enable_ok && frame_ok && !lock_hit;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      write_start  <= 1'b0;
      write_reject <= 1'b0;
    end else begin
      write_start  <= accepted && permit;
      write_reject <= accepted && !permit;
    end
  end
endmodule

// File: rtl/nvw_gate_chk.sv
module nvw_gate_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       busy,
  input logic       wp_pin,
  input logic       wel,
  input logic       rwel,
  input logic [1:0] req_target,
  input logic       frame_ok,
  input logic       lock_hit,
  input logic       write_start,
  input logic       write_reject
);
  // R7
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(write_start && write_reject));
  // R7
  accept_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy) |=> (write_start || write_reject));
  // R8
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && busy) |=> !(write_start || write_reject));
  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !(write_start || write_reject));
  // R5
  wp_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && wp_pin) |=> write_reject);
  // R2
  wel_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && !wel) |=> write_reject);
  // R3
  rwel_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && req_target == 2'b10 && !rwel) |=> write_reject);
  // R6
  frame_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && !frame_ok) |=> write_reject);
  // R4
  lock_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && lock_hit) |=> write_reject);
  // R10
  bad_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && req_target == 2'b11) |=> write_reject);
endmodule

bind nvw_gate nvw_gate_chk chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .busy         (busy),
  .wp_pin       (wp_pin),
  .wel          (wel),
  .rwel         (rwel),
  .req_target   (req_target),
  .frame_ok     (frame_ok),
  .lock_hit     (lock_hit),
  .write_start  (write_start),
  .write_reject (write_reject)
);

// File: tb/nvw_gate_test.sv
module nvw_gate_test;
  localparam int ADDR_W = 8;
  localparam int CNT_W  = 8;
  localparam int MINB   = 2;
  localparam int ASIZE  = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_target = 2'b00;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [CNT_W-1:0] bit_count = '0;
  logic ack_ok = 1'b0, wel = 1'b0, rwel = 1'b0, wp_pin = 1'b0, busy = 1'b0;
  logic [1:0] lock_code = 2'b00;
  logic write_start, write_reject;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  nvw_gate #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .MIN_BYTES(MINB)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_target(req_target),
    .req_addr(req_addr), .bit_count(bit_count), .ack_ok(ack_ok), .wel(wel),
    .rwel(rwel), .lock_code(lock_code), .wp_pin(wp_pin), .busy(busy),
    .write_start(write_start), .write_reject(write_reject)
  );

  // Returns the first rule that refuses the request, or "R1" when it passes.
  function automatic string refusal(input logic [1:0] t, input int a, input int bc,
                                    input logic ak, input logic we, input logic rwe,
                                    input logic [1:0] lk, input logic wp);
    int floor_addr;
    if (wp) return "R5";
    if (!we) return "R2";
    if (t == 2'b11) return "R10";
    if (t == 2'b10 && !rwe) return "R3";
    if (!ak || bc == 0 || (bc - (bc / 9) * 9) != 0 || bc < 9 * MINB) return "R6";
    floor_addr = (lk == 2'b01) ? (ASIZE * 3) / 4 : (lk == 2'b10) ? ASIZE / 2 : 0;
    if (t == 2'b00 && lk != 2'b00 && a >= floor_addr) return "R4";
    if (t == 2'b01 && lk == 2'b11) return "R4";
    return "R1";
  endfunction

  task automatic check(input string tag, input logic s, input logic r,
                       input logic es, input logic er);
    checks++;
    if (s !== es || r !== er) begin
      errors++;
      $display("FAIL %s: start/reject=%b%b expected %b%b", tag, s, r, es, er);
    end
  endtask

  task automatic request(input logic [1:0] t, input int a, input int bc,
                         input logic ak, input logic we, input logic rwe,
                         input logic [1:0] lk, input logic wp, input logic bz);
    string tag;
    @(negedge clk);
    req_target = t; req_addr = ADDR_W'(a); bit_count = CNT_W'(bc);
    ack_ok = ak; wel = we; rwel = rwe; lock_code = lk; wp_pin = wp; busy = bz;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    busy = 1'b0;
    tag = refusal(t, a, bc, ak, we, rwe, lk, wp);
    if (bz) check("R8", write_start, write_reject, 1'b0, 1'b0);
    else if (tag == "R1") check("R1", write_start, write_reject, 1'b1, 1'b0);
    else check({tag, "/R7"}, write_start, write_reject, 1'b0, 1'b1);
    @(negedge clk);
    // R1 R7: the pulse lasts a single cycle
    check("R7", write_start, write_reject, 1'b0, 1'b0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R9: outputs low in reset
    check("R9", write_start, write_reject, 1'b0, 1'b0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R9", write_start, write_reject, 1'b0, 1'b0);

    // Directed: plain passes on each valid target
    request(2'b00, 5, 18, 1, 1, 0, 2'b00, 0, 0);      // R1
    request(2'b01, 0, 27, 1, 1, 0, 2'b00, 0, 0);      // R1
    request(2'b10, 0, 18, 1, 1, 1, 2'b00, 0, 0);      // R1
    request(2'b10, 0, 18, 1, 1, 0, 2'b00, 0, 0);      // R3
    request(2'b00, 5, 18, 1, 0, 1, 2'b00, 0, 0);      // R2
    request(2'b00, 5, 18, 1, 1, 1, 2'b00, 1, 0);      // R5
    request(2'b11, 5, 18, 1, 1, 1, 2'b00, 0, 0);      // R10
    request(2'b00, 5, 17, 1, 1, 1, 2'b00, 0, 0);      // R6 one bit short
    request(2'b00, 5, 19, 1, 1, 1, 2'b00, 0, 0);      // R6 one bit over
    request(2'b00, 5, 9, 1, 1, 1, 2'b00, 0, 0);       // R6 too few bytes
    request(2'b00, 5, 18, 0, 1, 1, 2'b00, 0, 0);      // R6 missing ack
    request(2'b00, 5, 18, 1, 1, 1, 2'b00, 0, 1);      // R8
    // R4 lock boundaries
    request(2'b00, 191, 18, 1, 1, 1, 2'b01, 0, 0);
    request(2'b00, 192, 18, 1, 1, 1, 2'b01, 0, 0);
    request(2'b00, 127, 18, 1, 1, 1, 2'b10, 0, 0);
    request(2'b00, 128, 18, 1, 1, 1, 2'b10, 0, 0);
    request(2'b00, 0, 18, 1, 1, 1, 2'b11, 0, 0);
    request(2'b01, 0, 18, 1, 1, 1, 2'b10, 0, 0);
    request(2'b01, 0, 18, 1, 1, 1, 2'b11, 0, 0);
    request(2'b10, 0, 18, 1, 1, 1, 2'b11, 0, 0);
    request(2'b00, 255, 18, 1, 1, 1, 2'b00, 0, 0);

    // Random mix biased toward near-valid requests
    for (int i = 0; i < 400; i++) begin
      int bc;
      int sel = $urandom_range(0, 9);
      bc = (sel < 6) ? 9 * $urandom_range(1, 6) : $urandom_range(0, 60);
      request(2'($urandom_range(0, 3)), $urandom_range(0, ASIZE - 1), bc,
              ($urandom_range(0, 9) != 0), ($urandom_range(0, 9) != 0),
              ($urandom_range(0, 3) != 0), 2'($urandom_range(0, 3)),
              ($urandom_range(0, 9) == 0), ($urandom_range(0, 9) == 0));
    end

    // R9: idle cycles give no pulse
    repeat (3) begin
      @(negedge clk);
      check("R9", write_start, write_reject, 1'b0, 1'b0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule